// File: doc/BRIEF.md
# Dual-Bank Cache with Independent Invalidation Queues

This block models a small cache split into two banks by line-address parity. Bank 0 owns the odd line addresses and bank 1 owns the even ones. Invalidate messages arrive on a coherence port in a fixed order. Each message is routed by address parity into its bank's invalidation FIFO. Each bank drains its own FIFO at its own pace, and nothing links the progress of one bank to the other. When one bank is congested or held back, a later invalidation in the other bank can take effect before an earlier one. A processor read can therefore see fresh state in one bank and a stale line in the other.

Processor reads are served by the bank that owns the address. A response comes back one cycle after the request, carrying a hit flag and the stored word. A fill port installs a line as valid with its data word, so that tests have something to invalidate. A per-bank drain-stall input and per-bank occupancy outputs let a test build a deliberate imbalance between the banks and watch it unwind.

Each bank selects a drain mode every cycle through a small state decision:
- DR_EMPTY: the FIFO is empty.
- DR_POP: the FIFO is not empty and the stall is low. The head entry is removed and its line is cleared.
- DR_HELD: the FIFO is not empty and the stall is high. Nothing is removed.

The mode moves to DR_EMPTY whenever the queue empties. It moves to DR_POP or DR_HELD from any mode when the queue holds entries, depending on that cycle's stall input.

Top module: `dual_bank_inval_cache`

## Requirements
- R1: A line address with bit 0 = 1 belongs to bank 0 and one with bit 0 = 0 belongs to bank 1. An accepted invalidate raises only its own bank's occupancy, by one.
- R2: A stall on one bank does not stop the other bank from draining.
- R3: Suppose bank 1 is stalled, an invalidate for an even address arrives, and then an invalidate for an odd address arrives. The odd line is cleared while the even line stays valid.
- R4: A read of a line whose invalidation is still queued returns hit = 1 and the old data word.
- R5: Each bank FIFO holds 8 entries. `inv_ready` is low while the target bank holds 8. A refused invalidate is not queued.
- R6: While `drain_stall[b]` is high, bank b removes nothing, so its occupancy does not fall.
- R7: An unstalled bank removes at most one entry per cycle, in arrival order, and clears that line's valid bit at the same clock edge.
- R8: `rsp_valid` follows `rd_valid` by one cycle. A read of an invalid line gives hit = 0 and data = 0.
- R9: After reset every line is invalid, both occupancies are 0 and `inv_ready` is 1.
- R10: A fill makes its line valid with the given word. If a fill and a drain hit the same line at the same clock edge, the line ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_valid | input | 1 | Invalidate request present |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_ready | output | 1 | Target bank FIFO can accept the request |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Line address to install |
| fill_data | input | DATA_W | Data word for the installed line |
| rd_valid | input | 1 | Processor read request |
| rd_addr | input | ADDR_W | Line address to read |
| rsp_valid | output | 1 | Read response present |
| rsp_hit | output | 1 | Line was valid |
| rsp_data | output | DATA_W | Stored word on a hit, zero on a miss |
| drain_stall | input | 2 | Per-bank drain hold (bit 0 = odd bank) |
| occ_odd | output | CNT_W | Bank 0 FIFO occupancy |
| occ_even | output | CNT_W | Bank 1 FIFO occupancy |

## Verification
The assertions check the following on every cycle:
- FIFO occupancy stays within its depth and changes by at most one per cycle.
- A stalled bank never loses entries.
- A drained line is invalid right after its drain edge.
- Responses follow requests by one cycle, and a miss carries zero data.

Only the bench's scenarios can show the cross-bank behaviours: an odd line cleared while an earlier even invalidation still waits, stale hits during that window, refusal at exactly eight queued entries, and the FIFO order of clearing. The bench shows these by comparing every response and occupancy with a reference model of both queues and the line array.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
    typedef enum logic [1:0] {
        DR_EMPTY,
        DR_POP,
        DR_HELD
    } drain_mode_e;
endpackage

// File: rtl/dbic_fifo.sv
module dbic_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign count     = cnt_q;
    assign head_data = mem_q[rptr_q];
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wptr_q] <= push_data;
                wptr_q        <= nxt(wptr_q);
            end
            if (do_pop) rptr_q <= nxt(rptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R5
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((CNT_W+1)'(cnt_q) <= (CNT_W+1)'($past(cnt_q)) + 1'b1)
              && ((CNT_W+1)'(cnt_q) + 1'b1 >= (CNT_W+1)'($past(cnt_q)))); // R7
endmodule

// File: rtl/dbic_bank.sv
module dbic_bank
    import dbic_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter int QDEPTH = 8,
    localparam int LINES = 1 << IDX_W,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              inv_push,
    input  logic [IDX_W-1:0]  inv_idx,
    output logic              q_full,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              line_valid,
    output logic [DATA_W-1:0] line_data,
    output logic [CNT_W-1:0]  occ
);
    logic              valid_q [LINES];
    logic [DATA_W-1:0] data_q  [LINES];
    logic [IDX_W-1:0]  head_idx;
    logic              q_empty, pop_en;
    drain_mode_e       mode;

    dbic_fifo #(.W(IDX_W), .DEPTH(QDEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (inv_push),
        .push_data (inv_idx),
        .pop       (pop_en),
        .head_data (head_idx),
        .full      (q_full),
        .empty     (q_empty),
        .count     (occ)
    );

    always_comb begin
        if (q_empty)    mode = DR_EMPTY;
        else if (stall) mode = DR_HELD;
        else            mode = DR_POP;
    end

    always_comb begin
        unique case (mode)
            DR_EMPTY: pop_en = 1'b0;
            DR_POP:   pop_en = 1'b1;
            DR_HELD:  pop_en = 1'b0;
            default:  pop_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                data_q[i]  <= '0;
            end
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                data_q[fill_idx]  <= fill_data;
            end
            if (pop_en) valid_q[head_idx] <= 1'b0;
        end
    end

    assign line_valid = valid_q[rd_idx];
    assign line_data  = data_q[rd_idx];

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !inv_push) |=> (occ == $past(occ))); // R6
    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> !valid_q[$past(head_idx)]); // R7
endmodule

// File: rtl/dual_bank_inval_cache.sv
module dual_bank_inval_cache #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int QDEPTH = 8,
    localparam int IDX_W = ADDR_W - 1,
    localparam int CNT_W = $clog2(QDEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ready,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    input  logic [1:0]        drain_stall,
    output logic [CNT_W-1:0]  occ_odd,
    output logic [CNT_W-1:0]  occ_even
);
    logic [1:0]        q_full;
    logic              line_v [2];
    logic [DATA_W-1:0] line_d [2];
    logic [CNT_W-1:0]  occ_w  [2];
    logic              inv_bank, fill_bank, rd_bank;

    // bank 0 owns odd lines, bank 1 owns even lines
    assign inv_bank  = ~inv_addr[0];
    assign fill_bank = ~fill_addr[0];
    assign rd_bank   = ~rd_addr[0];
    assign inv_ready = ~q_full[inv_bank];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic OWN_PAR = (b == 0) ? 1'b1 : 1'b0;
        logic sel_inv, sel_fill;
        assign sel_inv  = inv_valid  && (inv_addr[0]  == OWN_PAR);
        assign sel_fill = fill_valid && (fill_addr[0] == OWN_PAR);

        dbic_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .stall      (drain_stall[b]),
            .inv_push   (sel_inv),
            .inv_idx    (inv_addr[ADDR_W-1:1]),
            .q_full     (q_full[b]),
            .fill_en    (sel_fill),
            .fill_idx   (fill_addr[ADDR_W-1:1]),
            .fill_data  (fill_data),
            .rd_idx     (rd_addr[ADDR_W-1:1]),
            .line_valid (line_v[b]),
            .line_data  (line_d[b]),
            .occ        (occ_w[b])
        );
    end

    assign occ_odd  = occ_w[0];
    assign occ_even = occ_w[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_valid;
            rsp_hit   <= rd_valid && line_v[rd_bank];
            rsp_data  <= (rd_valid && line_v[rd_bank]) ? line_d[rd_bank] : '0;
        end
    end

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rsp_valid); // R8
    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0)); // R8
    AST_REFUSE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_addr[0] && !inv_ready && !(occ_odd != '0 && !drain_stall[0]))
            |=> (occ_odd == $past(occ_odd))); // R5
    AST_ODD_SPARES_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_addr[0] && drain_stall[1]) |=> (occ_even == $past(occ_even))); // R1
endmodule

// File: tb/dual_bank_inval_cache_tb_top.sv
module dual_bank_inval_cache_tb_top;
    localparam int AW = 5, DW = 16, QD = 8, CW = 4, NL = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic inv_valid = 0, fill_valid = 0, rd_valid = 0;
    logic [AW-1:0] inv_addr = '0, fill_addr = '0, rd_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic [1:0] drain_stall = '0;
    logic inv_ready, rsp_valid, rsp_hit;
    logic [DW-1:0] rsp_data;
    logic [CW-1:0] occ_odd, occ_even;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic          mvalid [NL];
    logic [DW-1:0] mdata  [NL];
    logic [AW-1:0] mq [2][QD];
    int            mcnt [2];

    always #5 clk = ~clk;

    dual_bank_inval_cache #(.ADDR_W(AW), .DATA_W(DW), .QDEPTH(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .inv_ready(inv_ready), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .drain_stall(drain_stall), .occ_odd(occ_odd), .occ_even(occ_even));

    function automatic int bank_of(input logic [AW-1:0] a);
        return a[0] ? 0 : 1;
    endfunction

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input int k);
        return DW'(16'hA500 ^ (a * 37) ^ (k * 16'h0101));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One cycle: inputs are set before the call, ends at the next falling edge.
    task automatic tick();
        logic ev, eh, acc;
        logic [DW-1:0] ed;
        logic [AW-1:0] pa [2];
        bit pe [2];
        int ib;
        #1;
        ib = bank_of(inv_addr);
        if (inv_valid) chk(inv_ready == (mcnt[ib] < QD), "R5 ready", inv_ready, mcnt[ib] < QD);
        acc = inv_valid && (mcnt[ib] < QD);
        ev  = rd_valid;
        eh  = rd_valid && mvalid[rd_addr];
        ed  = eh ? mdata[rd_addr] : '0;
        @(posedge clk);
        cyc++;
        #1;
        for (int b = 0; b < 2; b++) begin
            pe[b] = (mcnt[b] > 0) && !drain_stall[b];
            pa[b] = mq[b][0];
            if (pe[b]) begin
                for (int i = 0; i < QD - 1; i++) mq[b][i] = mq[b][i+1];
                mcnt[b]--;
            end
        end
        if (fill_valid) begin
            mvalid[fill_addr] = 1'b1;
            mdata[fill_addr]  = fill_data;
        end
        for (int b = 0; b < 2; b++) if (pe[b]) mvalid[pa[b]] = 1'b0;
        if (acc) begin
            mq[ib][mcnt[ib]] = inv_addr;
            mcnt[ib]++;
        end
        chk(rsp_valid == ev, "R8 rsp_valid", rsp_valid, ev);
        if (ev) begin
            chk(rsp_hit == eh, "R4 hit", rsp_hit, eh);
            chk(rsp_data == ed, "R8 data", rsp_data, ed);
        end
        chk(occ_odd == CW'(mcnt[0]), "R7 occ_odd", occ_odd, mcnt[0]);
        chk(occ_even == CW'(mcnt[1]), "R1 occ_even", occ_even, mcnt[1]);
        @(negedge clk);
    endtask

    task automatic idle_in();
        inv_valid = 0; fill_valid = 0; rd_valid = 0;
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        idle_in(); rd_valid = 1; rd_addr = a; tick(); rd_valid = 0;
    endtask

    initial begin
        int wd = 0;
        while (wd < 200000) begin @(posedge clk); wd++; end
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NL; i++) begin mvalid[i] = 0; mdata[i] = '0; end
        mcnt[0] = 0; mcnt[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R9: reset state at the ports
        chk(occ_odd == 0 && occ_even == 0, "R9 occupancy", {occ_odd, occ_even}, 0);
        chk(inv_ready == 1'b1, "R9 ready", inv_ready, 1);
        chk(rsp_valid == 1'b0, "R9 rsp_valid", rsp_valid, 0);
        for (int a = 0; a < NL; a++) begin
            do_read(AW'(a));
            chk(rsp_hit == 1'b0, "R9 line invalid", rsp_hit, 0);
        end

        // R10: fill every line, then read back
        for (int a = 0; a < NL; a++) begin
            idle_in(); fill_valid = 1; fill_addr = AW'(a); fill_data = pattern(AW'(a), 1); tick();
        end
        idle_in();
        do_read(5'd6);
        chk(rsp_hit && rsp_data == pattern(5'd6, 1), "R10 fill hit", rsp_data, pattern(5'd6, 1));

        // R3 / R4 / R2: even bank stalled, even invalidate first, odd second
        drain_stall = 2'b10;
        idle_in(); inv_valid = 1; inv_addr = 5'd4; tick();
        idle_in(); inv_valid = 1; inv_addr = 5'd3; tick();
        idle_in(); tick();
        chk(occ_odd == 0, "R2 odd bank drained", occ_odd, 0);
        chk(occ_even == 1, "R6 even bank held", occ_even, 1);
        do_read(5'd3);
        chk(rsp_hit == 1'b0, "R3 later invalidate visible", rsp_hit, 0);
        do_read(5'd4);
        chk(rsp_hit == 1'b1 && rsp_data == pattern(5'd4, 1), "R4 stale line returned", rsp_data, pattern(5'd4, 1));
        drain_stall = 2'b00;
        idle_in(); tick();
        do_read(5'd4);
        chk(rsp_hit == 1'b0, "R7 cleared after release", rsp_hit, 0);

        // R5: fill odd queue to 8 while stalled; 9th refused, even still accepted
        drain_stall = 2'b01;
        for (int k = 0; k < QD; k++) begin
            idle_in(); inv_valid = 1; inv_addr = AW'(2 * k + 1); tick();
        end
        idle_in(); inv_valid = 1; inv_addr = 5'd17; #1;
        chk(inv_ready == 1'b0, "R5 full refuses", inv_ready, 0);
        tick();
        chk(occ_odd == CW'(QD), "R5 refused not queued", occ_odd, QD);
        idle_in(); inv_valid = 1; inv_addr = 5'd18; #1;
        chk(inv_ready == 1'b1, "R1 even port free", inv_ready, 1);
        tick();
        // R7: release, one per cycle in arrival order
        drain_stall = 2'b00;
        idle_in(); tick();
        chk(occ_odd == CW'(QD - 1), "R7 one per cycle", occ_odd, QD - 1);
        do_read(5'd1);
        chk(rsp_hit == 1'b0, "R7 head cleared first", rsp_hit, 0);
        do_read(5'd15);
        chk(rsp_hit == 1'b1, "R7 tail still valid", rsp_hit, 1);
        repeat (8) begin idle_in(); tick(); end

        // R10: fill and drain of the same line on the same edge
        idle_in(); fill_valid = 1; fill_addr = 5'd9; fill_data = 16'h1234; tick();
        drain_stall = 2'b01;
        idle_in(); inv_valid = 1; inv_addr = 5'd9; tick();
        drain_stall = 2'b00;
        idle_in(); fill_valid = 1; fill_addr = 5'd9; fill_data = 16'h5678; tick();
        do_read(5'd9);
        chk(rsp_hit == 1'b0, "R10 drain wins over fill", rsp_hit, 0);

        // Random phase, checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            inv_valid   = ($urandom % 3) == 0;
            inv_addr    = AW'($urandom);
            fill_valid  = ($urandom % 4) == 0;
            fill_addr   = AW'($urandom);
            fill_data   = DW'($urandom);
            rd_valid    = ($urandom % 2) == 0;
            rd_addr     = AW'($urandom);
            drain_stall = (n % 200 < 100) ? 2'($urandom % 4) : {1'b0, 1'($urandom % 2)};
            tick();
        end
        idle_in(); drain_stall = 2'b00;
        repeat (10) tick();
        chk(occ_odd == 0 && occ_even == 0, "R7 queues empty at end", {occ_odd, occ_even}, 0);
        summary();
    end
endmodule